// File: doc/BRIEF.md
# Lock-After-First-Write Watchdog Timer

This block is a watchdog timer driven through one write-only register. The first write after reset configures it. That write decides whether the watchdog counts at all, whether an expiry raises an interrupt or a reset request, and whether the count is slowed by a fixed prescaler. It also supplies the reload value and starts the first countdown. After that the configuration is frozen until the next reset. Every later write to the register, whatever its data, only restarts the countdown from the stored reload value.

Counting runs on a clock enable at half the bus clock rate. With the prescaler on, that rate is divided further by a fixed factor. When the countdown reaches zero, the block pulses the selected output for one cycle. The counter then rests at zero until software writes again. Software keeps the system alive by writing to the register more often than the configured period.

Top module: `oneshot_wdog`

## Requirements
- R1: An active-low asynchronous reset clears the lock, the counter and both outputs. Both outputs stay low during reset and after it until a new configuration times out, and a countdown cut short by reset never fires.
- R2: The first write after reset is the configuration write. Bit 31 enables counting, bit 30 picks the action (1 = reset request, 0 = interrupt), bit 29 enables the prescaler, and bits 11:0 give the reload value. Bits 28:12 are ignored. The write loads the counter with the reload value.
- R3: Once locked, a write with any data only reloads the counter with the stored reload value. The enable, action, prescale and reload settings do not change.
- R4: With the prescaler off, the selected output is high in the cycle after clock edge L+2R. Here L is the edge that samples the loading write and R is the reload value (1 to 4095).
- R5: With the prescaler on, the selected output is high in the cycle after edge L+512R, because the prescale factor is 256.
- R6: A timeout drives only the selected output, for exactly one cycle. The other output stays low.
- R7: After a timeout the counter holds at zero and no further pulse appears until the next write.
- R8: Each write restarts both the count and the tick phase, so writes spaced closer than the period prevent any timeout.
- R9: A write sampled on the same edge where the count would expire suppresses that pulse. A new full period starts from that write.
- R10: A configuration write with bit 31 clear locks the block, but it never counts or fires, even after later writes.
- R11: A reload value of zero never produces a timeout.
- R12: Before the configuration write nothing counts and neither output is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | One-cycle strobe marking a write to the register |
| wr_data | input | 32 | Write data; decoded only on the first write after reset |
| irq_o | output | 1 | One-cycle timeout interrupt |
| rst_req_o | output | 1 | One-cycle timeout reset request |

## Verification
The assertions assume that `wr_en` is a known, synchronous strobe. They also assume that each write lasts one cycle, that `wr_data` is valid while it is high, and that reset is asserted from time zero. Disable conditions use the internally synchronized reset.

The stimulus drives every input on the falling clock edge and holds reset low for several cycles. It issues writes only after the two-stage release has completed, and it never overlaps a write with reset. The timeout cycles it expects are placed by counting edges from the edge that samples each write.

// File: rtl/oneshot_wdog_pkg.sv
package oneshot_wdog_pkg;

  typedef enum logic {
    ACT_IRQ = 1'b0,
    ACT_RST = 1'b1
  } wd_act_e;

  typedef struct packed {
    logic    en;
    wd_act_e act;
    logic    psc_en;
  } wd_cfg_t;

endpackage

// File: rtl/wd_rst_sync.sv
module wd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wd_cfg_lock.sv
module wd_cfg_lock
  import oneshot_wdog_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int RELOAD_W = 12,
  parameter int EN_BIT   = 31,
  parameter int ACT_BIT  = 30,
  parameter int PSC_BIT  = 29
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                locked_o,
  output wd_cfg_t             cfg_o,
  output logic                load_o,
  output logic [RELOAD_W-1:0] load_val_o
);
  logic                locked_q, locked_d;
  wd_cfg_t             cfg_q, cfg_d;
  logic [RELOAD_W-1:0] reload_q, reload_d;
  logic                unused_wdata;

  assign unused_wdata = ^wr_data;

  always_comb begin
    locked_d = locked_q;
    cfg_d    = cfg_q;
    reload_d = reload_q;
    if (wr_en && !locked_q) begin
      locked_d     = 1'b1;
      cfg_d.en     = wr_data[EN_BIT];
      cfg_d.act    = wd_act_e'(wr_data[ACT_BIT]);
      cfg_d.psc_en = wr_data[PSC_BIT];
      reload_d     = wr_data[RELOAD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      cfg_q    <= '0;
      reload_q <= '0;
    end else begin
      locked_q <= locked_d;
      cfg_q    <= cfg_d;
      reload_q <= reload_d;
    end
  end

  assign locked_o   = locked_q;
  assign cfg_o      = cfg_q;
  assign load_o     = wr_en;
  assign load_val_o = locked_q ? reload_q : wr_data[RELOAD_W-1:0];

  // R3
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> (locked_q && $stable(cfg_q) && $stable(reload_q)));
endmodule

// File: rtl/wd_tick_gen.sv
module wd_tick_gen #(
  parameter int PRESCALE = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic psc_en,
  output logic tick_o
);
  localparam int PSC_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic half_q, half_d;
  logic half_tick;
  logic psc_hit;

  always_comb begin
    if (restart)  half_d = 1'b0;
    else if (run) half_d = ~half_q;
    else          half_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= half_d;
  end

  assign half_tick = half_q && run && !restart;

  generate
    if (PRESCALE > 1) begin : g_psc
      logic [PSC_W-1:0] psc_q, psc_d;
      logic             psc_wrap;

      assign psc_wrap = (psc_q == PSC_W'(PRESCALE - 1));

      always_comb begin
        psc_d = psc_q;
        if (restart)                  psc_d = '0;
        else if (half_tick && psc_en) psc_d = psc_wrap ? '0 : psc_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psc_q <= '0;
        else        psc_q <= psc_d;
      end

      assign psc_hit = psc_wrap;
    end else begin : g_nopsc
      assign psc_hit = 1'b1;
    end
  endgenerate

  assign tick_o = half_tick && (!psc_en || psc_hit);

  // R4
  half_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_q && !restart) |=> !half_q);
endmodule

// File: rtl/wd_down_cnt.sv
module wd_down_cnt
  import oneshot_wdog_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  wd_act_e          act,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             rreq_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic             rreq_q, rreq_d;
  logic             terminal;

  assign terminal = !load && tick && (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load)                        cnt_d = load_val;
    else if (tick && cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    irq_d  = terminal && (act == ACT_IRQ);
    rreq_d = terminal && (act == ACT_RST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      irq_q  <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      irq_q  <= irq_d;
      rreq_q <= rreq_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign irq_o  = irq_q;
  assign rreq_o = rreq_q;

  // R7
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load) |=> (cnt_q == '0));

  // R4
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/oneshot_wdog.sv
module oneshot_wdog
  import oneshot_wdog_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int RELOAD_W    = 12,
  parameter int EN_BIT      = 31,
  parameter int ACT_BIT     = 30,
  parameter int PSC_BIT     = 29,
  parameter int PRESCALE    = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic                rst_sync_n;
  logic                locked;
  wd_cfg_t             cfg;
  logic                load;
  logic [RELOAD_W-1:0] load_val;
  logic [RELOAD_W-1:0] cnt;
  logic                run;
  logic                tick;

  wd_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wd_cfg_lock #(
    .DATA_W   (DATA_W),
    .RELOAD_W (RELOAD_W),
    .EN_BIT   (EN_BIT),
    .ACT_BIT  (ACT_BIT),
    .PSC_BIT  (PSC_BIT)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .locked_o   (locked),
    .cfg_o      (cfg),
    .load_o     (load),
    .load_val_o (load_val)
  );

  assign run = locked && cfg.en && (cnt != '0);

  wd_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (run),
    .restart (load),
    .psc_en  (cfg.psc_en),
    .tick_o  (tick)
  );

  wd_down_cnt #(.CNT_W(RELOAD_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (load),
    .load_val (load_val),
    .tick     (tick),
    .act      (cfg.act),
    .cnt_o    (cnt),
    .irq_o    (irq_o),
    .rreq_o   (rst_req_o)
  );

  // R12
  preconfig_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !locked |=> !(irq_o || rst_req_o));

  // R9
  retrig_mask_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && locked) |=> !(irq_o || rst_req_o));

  // R6
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_o || rst_req_o) |=> !(irq_o || rst_req_o));

  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (locked && !cfg.en) |=> !(irq_o || rst_req_o));
endmodule

// File: tb/oneshot_wdog_test.sv
module oneshot_wdog_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        irq_o;
  logic        rst_req_o;

  always #2 clk = ~clk;

  oneshot_wdog uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );

  typedef struct {
    int    at;
    bit    kind;
    string tag;
  } exp_t;

  exp_t  sb[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  int    pulses = 0;
  string ctx = "R12";

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops expected pulses as the outputs show them
  exp_t e;
  always @(negedge clk) begin
    if (irq_o || rst_req_o) begin
      pulses++;
      n_chk++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL %s unexpected pulse at cycle %0d: irq=%b rreq=%b, expected none",
                 ctx, cyc, irq_o, rst_req_o);
      end else begin
        e = sb.pop_front();
        if (e.at != cyc || irq_o != !e.kind || rst_req_o != e.kind) begin
          n_fail++;
          $display("FAIL %s pulse: cycle=%0d irq=%b rreq=%b, expected cycle=%0d irq=%b rreq=%b",
                   e.tag, cyc, irq_o, rst_req_o, e.at, !e.kind, e.kind);
        end
      end
    end else if (sb.size() > 0 && sb[0].at < cyc) begin
      e = sb.pop_front();
      n_chk++;
      n_fail++;
      $display("FAIL %s missing pulse: none by cycle %0d, expected at %0d kind=%0d",
               e.tag, cyc, e.at, e.kind);
    end
  end

  function automatic logic [31:0] cw(bit en, bit act, bit psc, int r);
    logic [11:0] rr;
    rr = r[11:0];
    return {en, act, psc, 17'b0, rr};
  endfunction

  task automatic wr(input logic [31:0] d, output int edge_n);
    wr_en   = 1'b1;
    wr_data = d;
    edge_n  = cyc + 1;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = 32'h5A5A_0F0F;
  endtask

  task automatic push(input int at, input bit kind, input string tag);
    exp_t x;
    x.at = at; x.kind = kind; x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic go_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic quiet(input int n, input string tag);
    int p0;
    ctx = tag;
    p0 = pulses;
    repeat (n) @(negedge clk);
    n_chk++;
    if (pulses != p0) begin
      n_fail++;
      $display("FAIL %s quiet window: pulses=%0d, expected 0", tag, pulses - p0);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (irq_o || rst_req_o) begin
      n_fail++;
      $display("FAIL R1 outputs in reset: irq=%b rreq=%b, expected 0 0", irq_o, rst_req_o);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int l, l2;
    @(negedge clk);
    do_reset();
    quiet(60, "R12");

    // R4: plain countdown, reload 5, interrupt action
    ctx = "R4";
    wr(cw(1, 0, 0, 5), l);
    push(l + 10, 1'b0, "R4");
    drain();
    quiet(80, "R7");

    // R3: all-ones data only retriggers, settings unchanged
    ctx = "R3";
    wr(32'hFFFF_FFFF, l);
    push(l + 10, 1'b0, "R3");
    drain();

    // R8: keepalive writes closer than the period
    ctx = "R8";
    for (int i = 0; i < 6; i++) begin
      wr(32'h0, l);
      repeat (6) @(negedge clk);
    end
    push(l + 10, 1'b0, "R8");
    drain();

    // R9: write lands on the expiry edge
    ctx = "R9";
    wr(32'h0, l);
    go_to(l + 9);
    wr(32'h1234_5678, l2);
    push(l2 + 10, 1'b0, "R9");
    drain();

    // R1: reset mid-count never fires, and unlocks
    wr(32'h0, l);
    repeat (4) @(negedge clk);
    do_reset();
    quiet(40, "R1");

    // R6: reset-request action; second config-looking write only retriggers
    ctx = "R6";
    wr(cw(1, 1, 0, 3), l);
    push(l + 6, 1'b1, "R6");
    drain();
    quiet(30, "R7");
    ctx = "R3";
    wr(cw(1, 0, 1, 100), l);
    push(l + 6, 1'b1, "R3");
    drain();

    // R2: ignored middle bits, reload 7
    do_reset();
    ctx = "R2";
    wr(cw(1, 0, 0, 7) | 32'h1ABC_D000, l);
    push(l + 14, 1'b0, "R2");
    drain();

    // R5: prescaled, reload 2, then retrigger mid-way
    do_reset();
    ctx = "R5";
    wr(cw(1, 0, 1, 2), l);
    push(l + 1024, 1'b0, "R5");
    drain();
    wr(32'h0, l);
    go_to(l + 700);
    wr(32'h0, l2);
    push(l2 + 1024, 1'b0, "R5");
    drain();

    // R4: largest reload
    do_reset();
    ctx = "R4";
    wr(cw(1, 0, 0, 4095), l);
    push(l + 8190, 1'b0, "R4");
    drain();

    // R10: disabled configuration stays silent
    do_reset();
    wr(cw(0, 0, 0, 2), l);
    quiet(100, "R10");
    wr(32'hFFFF_FFFF, l);
    quiet(100, "R10");

    // R11: zero reload stays silent
    do_reset();
    wr(cw(1, 0, 0, 0), l);
    quiet(60, "R11");
    wr(32'h0, l);
    quiet(60, "R11");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d, expected run to finish", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule